// File: doc/BRIEF.md
# Quota-Limited Miss Tracking Register File

This block keeps track of cache misses that are still waiting on refill data in a non-blocking private cache, so the core can leave several misses outstanding while hits go on being served. Each access arrives with the hit or miss result already decided by the tag lookup. A miss to a block that already has a tracking entry joins that entry as an extra waiting target. Any other miss takes the lowest-numbered free entry and queues one refill request for the next level. When a refill comes back, the block replays the waiting targets one per cycle and then frees the entry.

Software sets a run-time quota on how many entries may be live at once, which can be lower than the physical entry count. A hardware counter always shows how many entries are in use. When the counter reaches the quota, or every physical entry is taken, the tracker locks up and refuses every access, hits included, until an entry retires.

Top module: `miss_quota_tracker`

## Requirements
- R1: After reset, used_count is 0, quota_q reads N_ENTRIES (6), fill_req_valid and rsp_valid are low, and req_ready is high.
- R2: An accepted miss (req_hit=0) whose block address matches no live entry takes the lowest-numbered free entry. used_count goes up by one at that clock edge.
- R3: An accepted miss whose address matches a live entry adds its (id, word) as a target of that entry. It does not change used_count and does not create a downstream request. An entry holds at most 4 targets, and a further miss to it sees req_ready low.
- R4: While the tracker is not locked, hits (req_hit=1) see req_ready high even if misses are outstanding.
- R5: The tracker is locked when used_count is at least the effective quota, or when all N_ENTRIES entries are live. While locked, req_ready is low for hits and misses alike.
- R6: A write on quota_wr_en stores quota_wr_data at the clock edge, and quota_q reads it back. A stored quota of 0 acts as a quota of 1.
- R7: If the quota is lowered below used_count, live entries still drain normally, and no access is accepted until used_count falls below the quota.
- R8: fill_req_valid is high while any live entry has not yet been issued. Entries are issued oldest allocation first, with fill_req_tag set to the entry index and fill_req_addr set to its block address. Both hold steady until fill_req_ready is seen high, and the issued entry is then dropped from the queue.
- R9: A refill accepted on fill_rsp_valid with fill_rsp_ready high, for entry fill_rsp_tag, produces rsp_valid on the next cycles, one target per cycle in arrival order, carrying the block address. fill_rsp_ready is low during this replay. At the edge that ends the last target's cycle, the entry is freed and used_count drops by one.
- R10: A miss to the block of an entry that is being replayed sees req_ready low. Once the entry is freed, the same miss allocates a fresh entry.
- R11: used_count always equals the number of live entries and never exceeds N_ENTRIES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access presented |
| req_hit | input | 1 | Tag lookup result: 1 hit, 0 miss |
| req_addr | input | ADDR_W | Block address of the access |
| req_id | input | ID_W | Requester id recorded as target |
| req_word | input | WORD_W | Word offset recorded as target |
| req_ready | output | 1 | Access accepted this cycle |
| quota_wr_en | input | 1 | Write strobe for the quota register |
| quota_wr_data | input | CNT_W | New quota value |
| quota_q | output | CNT_W | Stored quota value |
| used_count | output | CNT_W | Number of live entries |
| fill_req_valid | output | 1 | Refill request pending |
| fill_req_ready | input | 1 | Next level takes the request |
| fill_req_addr | output | ADDR_W | Block address to refill |
| fill_req_tag | output | IDX_W | Entry index of the request |
| fill_rsp_valid | input | 1 | Refill data returned |
| fill_rsp_tag | input | IDX_W | Entry index of the returned refill |
| fill_rsp_ready | output | 1 | Refill can be taken |
| rsp_valid | output | 1 | Target replay valid |
| rsp_addr | output | ADDR_W | Block address of replayed target |
| rsp_id | output | ID_W | Requester id of replayed target |
| rsp_word | output | WORD_W | Word offset of replayed target |

## Verification
A live-count that drifts from the real set of live entries shows at req_ready. It stalls hits too early, or lets an allocation through past the quota, on the very next access after the drift. A corrupt target slot or pointer shows as a wrong rsp_id or rsp_word in the cycle after a refill is taken. A lost or reordered issue queue shows as a wrong fill_req_tag on the next handshake. Each of these is checked at the first cycle in which it can show at the ports.

// File: rtl/mqt_pkg.sv
package mqt_pkg;
   // Outcome of one access at the request port.
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_HIT   = 2'd1,
      ACC_MERGE = 2'd2,
      ACC_ALLOC = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/mqt_entry.sv
module mqt_entry #(
   parameter int ADDR_W  = 26,
   parameter int ID_W    = 4,
   parameter int WORD_W  = 3,
   parameter int MAX_TGT = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       alloc_i,
   input  logic                       merge_i,
   input  logic                       issue_i,
   input  logic                       drain_i,
   input  logic                       clear_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [ID_W-1:0]            id_i,
   input  logic [WORD_W-1:0]          word_i,
   input  logic [$clog2(MAX_TGT)-1:0] rd_sel_i,
   output logic                       valid_o,
   output logic                       issued_o,
   output logic                       draining_o,
   output logic [ADDR_W-1:0]          addr_o,
   output logic [$clog2(MAX_TGT+1)-1:0] tcount_o,
   output logic [ID_W-1:0]            id_o,
   output logic [WORD_W-1:0]          word_o
);
   localparam int TC_W = $clog2(MAX_TGT+1);

   logic              valid_q, issued_q, drain_q;
   logic [TC_W-1:0]   tcnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ID_W-1:0]   id_vec [MAX_TGT];
   logic [WORD_W-1:0] wd_vec [MAX_TGT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         issued_q <= 1'b0;
         drain_q  <= 1'b0;
         tcnt_q   <= '0;
      end else if (alloc_i) begin
         valid_q  <= 1'b1;
         issued_q <= 1'b0;
         drain_q  <= 1'b0;
         tcnt_q   <= TC_W'(1);
      end else begin
         if (merge_i) tcnt_q   <= tcnt_q + TC_W'(1);
         if (issue_i) issued_q <= 1'b1;
         if (drain_i) drain_q  <= 1'b1;
         if (clear_i) begin
            valid_q  <= 1'b0;
            issued_q <= 1'b0;
            drain_q  <= 1'b0;
            tcnt_q   <= '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (alloc_i) addr_q <= addr_i;
   end

   for (genvar t = 0; t < MAX_TGT; t++) begin : g_tgt
      logic              wr_t;
      logic [ID_W-1:0]   id_q;
      logic [WORD_W-1:0] wd_q;
      assign wr_t = (alloc_i && (t == 0)) || (merge_i && (tcnt_q == TC_W'(t)));
      always_ff @(posedge clk) begin
         if (wr_t) begin
            id_q <= id_i;
            wd_q <= word_i;
         end
      end
      assign id_vec[t] = id_q;
      assign wd_vec[t] = wd_q;
   end

   assign valid_o    = valid_q;
   assign issued_o   = issued_q;
   assign draining_o = drain_q;
   assign addr_o     = addr_q;
   assign tcount_o   = tcnt_q;
   assign id_o       = id_vec[rd_sel_i];
   assign word_o     = wd_vec[rd_sel_i];

   AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> !valid_q); // R2
   AST_TGT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      merge_i |-> (valid_q && !drain_q && tcnt_q < TC_W'(MAX_TGT))); // R3
   AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |-> (valid_q && !issued_q)); // R8
   AST_DRAIN_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      drain_i |-> (valid_q && issued_q)); // R9
endmodule

// File: rtl/mqt_pick.sv
module mqt_pick #(
   parameter int N      = 6,
   parameter int ADDR_W = 26,
   parameter int IDX_W  = 3
) (
   input  logic [N-1:0]             valid_i,
   input  logic [N-1:0][ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0]        key_i,
   output logic [N-1:0]             match_o,
   output logic                     match_any_o,
   output logic [IDX_W-1:0]         match_idx_o,
   output logic                     free_any_o,
   output logic [IDX_W-1:0]         free_idx_o
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign match_o[i] = valid_i[i] && (addr_i[i] == key_i);
   end

   // Walk downward so the lowest index wins.
   always_comb begin
      match_idx_o = '0;
      free_idx_o  = '0;
      free_any_o  = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match_o[i]) match_idx_o = IDX_W'(i);
         if (!valid_i[i]) begin
            free_idx_o = IDX_W'(i);
            free_any_o = 1'b1;
         end
      end
   end

   assign match_any_o = |match_o;
endmodule

// File: rtl/mqt_order_fifo.sv
module mqt_order_fifo #(
   parameter int DEPTH = 6,
   parameter int W     = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] data_i,
   input  logic         pop_i,
   output logic [W-1:0] head_o,
   output logic         empty_o
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH+1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_q, wr_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_i) wr_q <= bump(wr_q);
         if (pop_i)  rd_q <= bump(rd_q);
         case ({push_i, pop_i})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_i) mem[wr_q] <= data_i;
   end

   assign head_o  = mem[rd_q];
   assign empty_o = (cnt_q == '0);

   AST_FIFO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> (cnt_q < CW'(DEPTH))); // R8
   AST_FIFO_POP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o); // R8
endmodule

// File: rtl/mqt_replay.sv
module mqt_replay #(
   parameter int IDX_W = 3,
   parameter int TC_W  = 3,
   parameter int TP_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [IDX_W-1:0] tag_i,
   input  logic [TC_W-1:0]  cur_tcount_i,
   output logic             busy_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [TP_W-1:0]  ptr_o,
   output logic             last_o
);
   logic             busy_q;
   logic [IDX_W-1:0] idx_q;
   logic [TP_W-1:0]  ptr_q;

   assign last_o = busy_q && ((TC_W'(ptr_q) + TC_W'(1)) == cur_tcount_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         ptr_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         idx_q  <= tag_i;
         ptr_q  <= '0;
      end else if (busy_q) begin
         if (last_o) busy_q <= 1'b0;
         else        ptr_q  <= ptr_q + TP_W'(1);
      end
   end

   assign busy_o = busy_q;
   assign idx_o  = idx_q;
   assign ptr_o  = ptr_q;

   AST_RPL_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_q); // R9
   AST_RPL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> !busy_q); // R9
endmodule

// File: rtl/miss_quota_tracker.sv
module miss_quota_tracker #(
   parameter int N_ENTRIES = 6,
   parameter int ADDR_W    = 26,
   parameter int ID_W      = 4,
   parameter int WORD_W    = 3,
   parameter int MAX_TGT   = 4,
   parameter int IDX_W     = $clog2(N_ENTRIES),
   parameter int CNT_W     = $clog2(N_ENTRIES+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_hit,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ID_W-1:0]   req_id,
   input  logic [WORD_W-1:0] req_word,
   output logic              req_ready,
   input  logic              quota_wr_en,
   input  logic [CNT_W-1:0]  quota_wr_data,
   output logic [CNT_W-1:0]  quota_q,
   output logic [CNT_W-1:0]  used_count,
   output logic              fill_req_valid,
   input  logic              fill_req_ready,
   output logic [ADDR_W-1:0] fill_req_addr,
   output logic [IDX_W-1:0]  fill_req_tag,
   input  logic              fill_rsp_valid,
   input  logic [IDX_W-1:0]  fill_rsp_tag,
   output logic              fill_rsp_ready,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [ID_W-1:0]   rsp_id,
   output logic [WORD_W-1:0] rsp_word
);
   import mqt_pkg::*;

   localparam int TC_W = $clog2(MAX_TGT+1);
   localparam int TP_W = $clog2(MAX_TGT);

   if (N_ENTRIES < 2 || MAX_TGT < 2) begin : g_bad_size
      $error("miss_quota_tracker: N_ENTRIES and MAX_TGT must be at least 2");
   end
   if (IDX_W < $clog2(N_ENTRIES) || CNT_W < $clog2(N_ENTRIES+1)) begin : g_bad_width
      $error("miss_quota_tracker: index or count width too narrow");
   end

   logic [N_ENTRIES-1:0]             ent_valid, ent_issued, ent_drain;
   logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_addr;
   logic [N_ENTRIES-1:0][TC_W-1:0]   ent_tcnt;
   logic [N_ENTRIES-1:0][ID_W-1:0]   ent_id;
   logic [N_ENTRIES-1:0][WORD_W-1:0] ent_wd;
   logic [N_ENTRIES-1:0]             alloc_vec, merge_vec, issue_vec, drain_vec, clear_vec;
   logic [N_ENTRIES-1:0]             match_vec;

   logic             match_any, free_any;
   logic [IDX_W-1:0] match_idx, free_idx;
   logic [CNT_W-1:0] quota_r, used_r, eff_quota;
   logic             locked, merge_blocked;
   acc_kind_e        acc;
   logic             do_alloc, do_merge;
   logic             q_empty, q_pop;
   logic [IDX_W-1:0] q_head;
   logic             fill_fire;
   logic             rpl_busy, rpl_last;
   logic [IDX_W-1:0] rpl_idx;
   logic [TP_W-1:0]  rpl_ptr;

   // Search and free-slot choice.
   mqt_pick #(.N(N_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pick (
      .valid_i     (ent_valid),
      .addr_i      (ent_addr),
      .key_i       (req_addr),
      .match_o     (match_vec),
      .match_any_o (match_any),
      .match_idx_o (match_idx),
      .free_any_o  (free_any),
      .free_idx_o  (free_idx)
   );

   // Quota and lockup.
   assign eff_quota = (quota_r == '0) ? CNT_W'(1) : quota_r;
   assign locked    = (used_r >= eff_quota) || (used_r == CNT_W'(N_ENTRIES));
   assign merge_blocked = match_any &&
                          (ent_drain[match_idx] || (ent_tcnt[match_idx] == TC_W'(MAX_TGT)));

   assign req_ready = !locked && !(!req_hit && merge_blocked);

   always_comb begin
      acc = ACC_NONE;
      if (req_valid && req_ready) begin
         if (req_hit)        acc = ACC_HIT;
         else if (match_any) acc = ACC_MERGE;
         else                acc = ACC_ALLOC;
      end
   end
   assign do_alloc = (acc == ACC_ALLOC);
   assign do_merge = (acc == ACC_MERGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) quota_r <= CNT_W'(N_ENTRIES);
      else if (quota_wr_en) quota_r <= quota_wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_r <= '0;
      end else begin
         case ({do_alloc, rpl_last})
            2'b10:   used_r <= used_r + CNT_W'(1);
            2'b01:   used_r <= used_r - CNT_W'(1);
            default: used_r <= used_r;
         endcase
      end
   end

   assign quota_q    = quota_r;
   assign used_count = used_r;

   // Issue order.
   mqt_order_fifo #(.DEPTH(N_ENTRIES), .W(IDX_W)) u_order (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (do_alloc),
      .data_i  (free_idx),
      .pop_i   (q_pop),
      .head_o  (q_head),
      .empty_o (q_empty)
   );

   assign fill_req_valid = !q_empty;
   assign fill_req_tag   = q_head;
   assign fill_req_addr  = ent_addr[q_head];
   assign q_pop          = fill_req_valid && fill_req_ready;

   // Refill replay.
   assign fill_rsp_ready = !rpl_busy;
   assign fill_fire      = fill_rsp_valid && fill_rsp_ready;

   mqt_replay #(.IDX_W(IDX_W), .TC_W(TC_W), .TP_W(TP_W)) u_replay (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (fill_fire),
      .tag_i        (fill_rsp_tag),
      .cur_tcount_i (ent_tcnt[rpl_idx]),
      .busy_o       (rpl_busy),
      .idx_o        (rpl_idx),
      .ptr_o        (rpl_ptr),
      .last_o       (rpl_last)
   );

   assign rsp_valid = rpl_busy;
   assign rsp_addr  = ent_addr[rpl_idx];
   assign rsp_id    = ent_id[rpl_idx];
   assign rsp_word  = ent_wd[rpl_idx];

   // Entry array.
   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
      assign alloc_vec[i] = do_alloc  && (free_idx     == IDX_W'(i));
      assign merge_vec[i] = do_merge  && match_vec[i];
      assign issue_vec[i] = q_pop     && (q_head       == IDX_W'(i));
      assign drain_vec[i] = fill_fire && (fill_rsp_tag == IDX_W'(i));
      assign clear_vec[i] = rpl_last  && (rpl_idx      == IDX_W'(i));

      mqt_entry #(.ADDR_W(ADDR_W), .ID_W(ID_W), .WORD_W(WORD_W), .MAX_TGT(MAX_TGT)) u_ent (
         .clk        (clk),
         .rst_n      (rst_n),
         .alloc_i    (alloc_vec[i]),
         .merge_i    (merge_vec[i]),
         .issue_i    (issue_vec[i]),
         .drain_i    (drain_vec[i]),
         .clear_i    (clear_vec[i]),
         .addr_i     (req_addr),
         .id_i       (req_id),
         .word_i     (req_word),
         .rd_sel_i   (rpl_ptr),
         .valid_o    (ent_valid[i]),
         .issued_o   (ent_issued[i]),
         .draining_o (ent_drain[i]),
         .addr_o     (ent_addr[i]),
         .tcount_o   (ent_tcnt[i]),
         .id_o       (ent_id[i]),
         .word_o     (ent_wd[i])
      );
   end

   AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      used_r == CNT_W'($countones(ent_valid))); // R11
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      used_r <= CNT_W'(N_ENTRIES)); // R11
   AST_ALLOC_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      do_alloc |-> free_any); // R2
   AST_QUOTA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      do_alloc |=> (used_r <= $past(eff_quota))); // R7
   AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec)); // R3
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req_valid && !fill_req_ready) |=>
         (fill_req_valid && $stable(fill_req_tag) && $stable(fill_req_addr))); // R8
   AST_FILL_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      fill_fire |-> (ent_valid[fill_rsp_tag] && ent_issued[fill_rsp_tag] &&
                     !ent_drain[fill_rsp_tag])); // R9
   AST_RSP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (ent_valid[rpl_idx] && ent_drain[rpl_idx])); // R9
endmodule

// File: tb/tb_miss_quota_tracker.sv
`timescale 1ns/1ps
module tb_miss_quota_tracker;
   localparam int AW = 26;
   localparam logic [1:0] OP_H = 2'd0, OP_M = 2'd1, OP_Q = 2'd2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_hit = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [3:0]    req_id = '0;
   logic [2:0]    req_word = '0;
   logic          req_ready;
   logic          quota_wr_en = 1'b0;
   logic [2:0]    quota_wr_data = '0;
   logic [2:0]    quota_q, used_count;
   logic          fill_req_valid, fill_req_ready = 1'b0;
   logic [AW-1:0] fill_req_addr;
   logic [2:0]    fill_req_tag;
   logic          fill_rsp_valid = 1'b0;
   logic [2:0]    fill_rsp_tag = '0;
   logic          fill_rsp_ready, rsp_valid;
   logic [AW-1:0] rsp_addr;
   logic [3:0]    rsp_id;
   logic [2:0]    rsp_word;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   miss_quota_tracker dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_hit(req_hit), .req_addr(req_addr),
      .req_id(req_id), .req_word(req_word), .req_ready(req_ready),
      .quota_wr_en(quota_wr_en), .quota_wr_data(quota_wr_data),
      .quota_q(quota_q), .used_count(used_count),
      .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
      .fill_req_addr(fill_req_addr), .fill_req_tag(fill_req_tag),
      .fill_rsp_valid(fill_rsp_valid), .fill_rsp_tag(fill_rsp_tag),
      .fill_rsp_ready(fill_rsp_ready), .rsp_valid(rsp_valid),
      .rsp_addr(rsp_addr), .rsp_id(rsp_id), .rsp_word(rsp_word)
   );

   typedef struct packed {
      logic [1:0]    op;
      logic [AW-1:0] addr;   // quota value for OP_Q rows
      logic [3:0]    id;
      logic [2:0]    word;
      logic          rdy;
      logic [2:0]    cnt;
      logic [3:0]    rq;
   } row_t;

   localparam int NROWS = 18;
   localparam row_t TBL [NROWS] = '{
      '{OP_Q, 26'd6,     4'd0, 3'd0, 1'b1, 3'd0, 4'd6},
      '{OP_M, 26'h100,   4'd1, 3'd0, 1'b1, 3'd1, 4'd2},
      '{OP_M, 26'h100,   4'd2, 3'd1, 1'b1, 3'd1, 4'd3},
      '{OP_H, 26'h777,   4'd0, 3'd0, 1'b1, 3'd1, 4'd4},
      '{OP_M, 26'h100,   4'd3, 3'd2, 1'b1, 3'd1, 4'd3},
      '{OP_M, 26'h100,   4'd4, 3'd3, 1'b1, 3'd1, 4'd3},
      '{OP_M, 26'h100,   4'd5, 3'd4, 1'b0, 3'd1, 4'd3},
      '{OP_M, 26'h200,   4'd6, 3'd0, 1'b1, 3'd2, 4'd2},
      '{OP_M, 26'h300,   4'd7, 3'd1, 1'b1, 3'd3, 4'd2},
      '{OP_H, 26'h777,   4'd0, 3'd0, 1'b1, 3'd3, 4'd4},
      '{OP_Q, 26'd3,     4'd0, 3'd0, 1'b1, 3'd3, 4'd6},
      '{OP_H, 26'h777,   4'd0, 3'd0, 1'b0, 3'd3, 4'd5},
      '{OP_M, 26'h100,   4'd9, 3'd0, 1'b0, 3'd3, 4'd5},
      '{OP_Q, 26'd0,     4'd0, 3'd0, 1'b1, 3'd3, 4'd6},
      '{OP_H, 26'h777,   4'd0, 3'd0, 1'b0, 3'd3, 4'd6},
      '{OP_Q, 26'd4,     4'd0, 3'd0, 1'b1, 3'd3, 4'd6},
      '{OP_M, 26'h400,   4'd8, 3'd2, 1'b1, 3'd4, 4'd2},
      '{OP_H, 26'h777,   4'd0, 3'd0, 1'b0, 3'd4, 4'd5}
   };

   task automatic check(input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic do_req(input logic hit, input logic [AW-1:0] a, input logic [3:0] id,
                         input logic [2:0] w, input logic exp_rdy,
                         input logic [2:0] exp_cnt, input string rq);
      @(negedge clk);
      req_valid = 1'b1; req_hit = hit; req_addr = a; req_id = id; req_word = w;
      #1 check(rq, "req_ready", req_ready, exp_rdy);
      @(posedge clk);
      #1 req_valid = 1'b0; req_hit = 1'b0;
      check(rq, "used_count", used_count, exp_cnt);
   endtask

   task automatic do_quota(input logic [2:0] v);
      @(negedge clk);
      quota_wr_en = 1'b1; quota_wr_data = v;
      @(posedge clk);
      #1 quota_wr_en = 1'b0;
   endtask

   task automatic issue_one(input logic [2:0] tag, input logic [AW-1:0] a, input string rq);
      @(negedge clk);
      fill_req_ready = 1'b1;
      #1 check(rq, "fill_req_valid", fill_req_valid, 1'b1);
      check(rq, "fill_req_tag", fill_req_tag, tag);
      check(rq, "fill_req_addr", fill_req_addr, a);
      @(posedge clk);
      #1 fill_req_ready = 1'b0;
   endtask

   task automatic refill(input logic [2:0] tag, input int n, input logic [3:0][3:0] ids,
                         input logic [3:0][2:0] wds, input logic [AW-1:0] a, input string rq);
      @(negedge clk);
      fill_rsp_valid = 1'b1; fill_rsp_tag = tag;
      #1 check(rq, "fill_rsp_ready", fill_rsp_ready, 1'b1);
      @(posedge clk);
      #1 fill_rsp_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         #1 check(rq, "rsp_valid", rsp_valid, 1'b1);
         check(rq, "rsp_id", rsp_id, ids[k]);
         check(rq, "rsp_word", rsp_word, wds[k]);
         check(rq, "rsp_addr", rsp_addr, a);
      end
      @(negedge clk);
      #1 check(rq, "rsp_valid end", rsp_valid, 1'b0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      @(negedge clk); #1;
      check("R1", "used_count", used_count, 3'd0);
      check("R1", "quota_q", quota_q, 3'd6);
      check("R1", "fill_req_valid", fill_req_valid, 1'b0);
      check("R1", "rsp_valid", rsp_valid, 1'b0);
      check("R1", "req_ready", req_ready, 1'b1);

      // R6: quota of 0 behaves as 1
      do_quota(3'd0);
      check("R6", "quota_q zero", quota_q, 3'd0);
      do_req(1'b0, 26'h0AA, 4'hA, 3'd1, 1'b1, 3'd1, "R6");
      do_req(1'b1, 26'h777, 4'h0, 3'd0, 1'b0, 3'd1, "R6");
      issue_one(3'd0, 26'h0AA, "R8");
      refill(3'd0, 1, {4'd0, 4'd0, 4'd0, 4'hA}, {3'd0, 3'd0, 3'd0, 3'd1}, 26'h0AA, "R9");
      check("R9", "used after retire", used_count, 3'd0);

      // Table walk: R2 R3 R4 R5 R6
      for (int r = 0; r < NROWS; r++) begin
         if (TBL[r].op == OP_Q) begin
            do_quota(TBL[r].addr[2:0]);
            check($sformatf("R%0d", TBL[r].rq), "quota_q", quota_q, TBL[r].addr[2:0]);
            check($sformatf("R%0d", TBL[r].rq), "used_count", used_count, TBL[r].cnt);
         end else begin
            do_req(TBL[r].op == OP_H, TBL[r].addr, TBL[r].id, TBL[r].word,
                   TBL[r].rdy, TBL[r].cnt, $sformatf("R%0d", TBL[r].rq));
         end
      end

      // R8: issue in allocation order; nothing left afterwards
      issue_one(3'd0, 26'h100, "R8");
      issue_one(3'd1, 26'h200, "R8");
      issue_one(3'd2, 26'h300, "R8");
      issue_one(3'd3, 26'h400, "R8");
      @(negedge clk); #1 check("R8", "queue empty", fill_req_valid, 1'b0);

      // R9 out-of-order refill, R4 hit reopens
      refill(3'd1, 1, {4'd0, 4'd0, 4'd0, 4'd6}, {3'd0, 3'd0, 3'd0, 3'd0}, 26'h200, "R9");
      check("R9", "used after retire", used_count, 3'd3);
      do_req(1'b1, 26'h777, 4'd0, 3'd0, 1'b1, 3'd3, "R4");

      // R7: quota lowered below live count
      do_quota(3'd2);
      do_req(1'b0, 26'h500, 4'd9, 3'd4, 1'b0, 3'd3, "R7");
      refill(3'd2, 1, {4'd0, 4'd0, 4'd0, 4'd7}, {3'd0, 3'd0, 3'd0, 3'd1}, 26'h300, "R7");
      do_req(1'b0, 26'h500, 4'd9, 3'd4, 1'b0, 3'd2, "R7");
      refill(3'd3, 1, {4'd0, 4'd0, 4'd0, 4'd8}, {3'd0, 3'd0, 3'd0, 3'd2}, 26'h400, "R7");
      do_req(1'b0, 26'h500, 4'd9, 3'd4, 1'b1, 3'd2, "R7");

      // R9 multi-target replay, R10 stall on draining block
      do_quota(3'd6);
      @(negedge clk);
      fill_rsp_valid = 1'b1; fill_rsp_tag = 3'd0;
      @(posedge clk);
      #1 fill_rsp_valid = 1'b0;
      req_valid = 1'b1; req_hit = 1'b0; req_addr = 26'h100; req_id = 4'hB; req_word = 3'd5;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); #1;
         check("R9", "rsp_valid", rsp_valid, 1'b1);
         check("R9", "rsp_id order", rsp_id, 4'(k + 1));
         check("R9", "rsp_word order", rsp_word, 3'(k));
         check("R10", "req_ready draining", req_ready, 1'b0);
         if (k == 0) check("R9", "fill_rsp_ready busy", fill_rsp_ready, 1'b0);
      end
      @(negedge clk); #1;
      check("R9", "rsp_valid end", rsp_valid, 1'b0);
      check("R9", "used after drain", used_count, 3'd1);
      check("R10", "req_ready after free", req_ready, 1'b1);
      @(posedge clk);
      #1 req_valid = 1'b0;
      check("R10", "realloc count", used_count, 3'd2);

      // R8 oldest unissued first: entry 1 (0x500) was allocated before entry 0
      issue_one(3'd1, 26'h500, "R8");
      issue_one(3'd0, 26'h100, "R8");

      // R5 / R11: physical limit with quota above entry count
      do_quota(3'd7);
      do_req(1'b0, 26'h600, 4'd1, 3'd0, 1'b1, 3'd3, "R11");
      do_req(1'b0, 26'h610, 4'd1, 3'd0, 1'b1, 3'd4, "R11");
      do_req(1'b0, 26'h620, 4'd1, 3'd0, 1'b1, 3'd5, "R11");
      do_req(1'b0, 26'h630, 4'd1, 3'd0, 1'b1, 3'd6, "R11");
      do_req(1'b1, 26'h777, 4'd0, 3'd0, 1'b0, 3'd6, "R5");
      do_req(1'b0, 26'h640, 4'd2, 3'd0, 1'b0, 3'd6, "R5");

      finish_run();
   end
endmodule